// File: doc/BRIEF.md
# Infrared Fast-Mode Frame CRC-32 Unit

This block produces and checks the 32-bit frame check sequence of an infrared fast-mode link. It has two separate CRC-32 generators, one for each direction, and they share no state. The transmit side takes the address, control and data bytes of a frame. A start strobe marks the first byte and an end-of-data strobe marks the last. Each byte is folded into the CRC one bit at a time, least significant bit first. After the end-of-data strobe, the transmit side sends the one's complement of the final CRC as a stream of nibbles. The least significant byte comes first, and the low nibble of each byte comes before its high nibble. The modulator that follows can then place the trailer ahead of the closing flag.

The receive side takes the demodulated frame as a bit stream that runs from a start strobe to an end strobe. It treats the last 32 bits as the received trailer and the earlier bits as covered data. One cycle after the end strobe it gives one of three single-cycle results: the check passed, the check failed, or the frame was aborted because its bit count was not a whole number of bytes. A parameter chooses how the check is done. In compare mode the complemented CRC is compared against the captured trailer. In residue mode the trailer is run through the CRC as well, and the final register is tested against the fixed CRC-32 residue.

Top module: `irf_fcs_unit`

## Requirements
- R1: After reset, `tx_busy`, `tx_nib_valid`, `tx_nib_last`, `rx_crc_ok`, `rx_crc_err` and `rx_abort` are all low.
- R2: The transmit CRC is the reflected CRC-32 (polynomial 0xEDB88320 shifted right, each byte fed bit 0 first). It is preset to 0xFFFFFFFF on a `tx_sof` cycle and covers every byte presented with `tx_valid`, from the `tx_sof` cycle up to and including the `tx_eod` cycle. The bytes "123456789" give the trailer value 0xCBF43926. A frame with no bytes gives 0x00000000.
- R3: In the cycle after `tx_eod`, `tx_nib_valid` rises. It stays high for exactly 8 cycles, and `tx_nib_last` is high on the 8th cycle only. `tx_nib` carries bits [3:0] of the complemented CRC first, then bits [7:4], then [11:8], and so on up to [31:28].
- R4: While `tx_busy` (equal to `tx_nib_valid`) is high, `tx_sof`, `tx_valid` and `tx_eod` are ignored. They do not change the trailer being sent, and they do not start another trailer.
- R5: On receive, `rx_sof` presets the CRC and clears the bit counts before the bit on that cycle is taken. Each bit with `rx_bit_valid` is taken in order, and a bit on the `rx_eof` cycle is included. The last 32 bits before the end are the trailer, and the first of them is trailer bit 0.
- R6: When the frame is whole bytes, has at least 32 bits, and its trailer equals the complement of the CRC over the earlier bits, `rx_crc_ok` is high for exactly one cycle, in the cycle after `rx_eof`.
- R7: `rx_crc_err` is high for exactly one cycle after `rx_eof` in two cases: the trailer does not match, or the frame is whole bytes but has fewer than 32 bits.
- R8: When the received bit count is not a multiple of 8, `rx_abort` is high for one cycle after `rx_eof`, and neither `rx_crc_ok` nor `rx_crc_err` rises.
- R9: Transmit and receive run concurrently without affecting each other.
- R10: With the residue check selected, frames give the same ok, error and abort results. In this mode the pass condition is that the CRC register holds 0xDEBB20E3 after all bits, trailer included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_sof | input | 1 | Preset the transmit CRC; marks first byte |
| tx_valid | input | 1 | `tx_byte` holds a covered byte |
| tx_byte | input | 8 | Address, control or data byte |
| tx_eod | input | 1 | Last covered byte; start trailer |
| tx_busy | output | 1 | Trailer in progress, inputs ignored |
| tx_nib_valid | output | 1 | `tx_nib` holds a trailer nibble |
| tx_nib | output | 4 | Trailer nibble, least significant first |
| tx_nib_last | output | 1 | Eighth and final trailer nibble |
| rx_sof | input | 1 | Preset the receive CRC and counters |
| rx_bit_valid | input | 1 | `rx_bit` holds a received bit |
| rx_bit | input | 1 | Received bit, byte LSB first |
| rx_eof | input | 1 | Frame ends with this cycle |
| rx_crc_ok | output | 1 | One-cycle pass result |
| rx_crc_err | output | 1 | One-cycle fail result |
| rx_abort | output | 1 | One-cycle partial-byte abort |

## Verification
On transmit, a wrong bit in the CRC register shows up in the trailer nibbles. Those nibbles appear from 1 to 8 cycles after end-of-data, so every covered byte is checked at the nibble level against the standard check value and against an independent bit-loop model. On receive, state cannot be seen until the result cycle. A miscounted bit position, a shifted trailer window or a skipped preset therefore shows up as the wrong result pulse, one cycle after the end strobe. For this reason, frames are checked for pass, single-bit corruption, short length and partial bytes. Transmit and receive also run together, so that any shared state would corrupt one of them.

// File: rtl/irf_fcs_pkg.sv
package irf_fcs_pkg;
    localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] FCS_PRESET    = 32'hFFFFFFFF;
    localparam logic [31:0] FCS_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic {
        CHK_COMPARE = 1'b0,
        CHK_RESIDUE = 1'b1
    } chk_mode_e;
endpackage

// File: rtl/irf_crc_step.sv
// Combinational LSB-first update of a reflected CRC by N input bits.
module irf_crc_step #(
    parameter int          CRC_W = 32,
    parameter int          N     = 8,
    parameter logic [31:0] POLY  = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [N-1:0]     din,
    output logic [CRC_W-1:0] crc_out
);
    localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];

    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < N; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ POLY_W;
            else               c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/irf_fcs_tx.sv
// Transmit path: byte-wise CRC accumulation and nibble trailer emission.
module irf_fcs_tx #(
    parameter int          CRC_W  = 32,
    parameter int          BYTE_W = 8,
    parameter int          NIB_W  = 4,
    parameter logic [31:0] POLY   = 32'hEDB88320,
    parameter logic [31:0] PRESET = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sof,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_eod,
    output logic              tx_busy,
    output logic              tx_nib_valid,
    output logic [NIB_W-1:0]  tx_nib,
    output logic              tx_nib_last
);
    localparam int NIBS  = CRC_W / NIB_W;
    localparam int CNT_W = $clog2(NIBS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NIBS - 1);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] trl;
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [CRC_W-1:0] base_crc;
    logic [CRC_W-1:0] step_crc;

    always_comb base_crc = tx_sof ? PRESET[CRC_W-1:0] : st_q.crc;

    irf_crc_step #(.CRC_W(CRC_W), .N(BYTE_W), .POLY(POLY)) u_step (
        .crc_in  (base_crc),
        .din     (tx_byte),
        .crc_out (step_crc)
    );

    always_comb begin
        logic [CRC_W-1:0] nxt;
        st_d = st_q;
        nxt  = tx_valid ? step_crc : base_crc;
        if (st_q.busy) begin
            st_d.trl = st_q.trl >> NIB_W;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) st_d.busy = 1'b0;
        end else begin
            st_d.crc = nxt;
            if (tx_eod) begin
                st_d.trl  = ~nxt;
                st_d.cnt  = '0;
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: PRESET[CRC_W-1:0], trl: '0, cnt: '0, busy: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_busy      = st_q.busy;
    assign tx_nib_valid = st_q.busy;
    assign tx_nib       = st_q.trl[NIB_W-1:0];
    assign tx_nib_last  = st_q.busy && (st_q.cnt == LAST_IDX);

    assert_trailer_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_nib_valid) |-> $past(tx_eod));
    assert_trailer_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nib_last |=> !tx_nib_valid);
    assert_trailer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_nib_valid && !tx_nib_last) |=> tx_nib_valid);
    assert_ignore_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(st_q.crc));
endmodule

// File: rtl/irf_fcs_rx.sv
// Receive path: bit-serial CRC with a trailer window, result on end strobe.
module irf_fcs_rx
    import irf_fcs_pkg::*;
#(
    parameter int          CRC_W   = 32,
    parameter int          BYTE_W  = 8,
    parameter logic [31:0] POLY    = 32'hEDB88320,
    parameter logic [31:0] PRESET  = 32'hFFFFFFFF,
    parameter logic [31:0] RESIDUE = 32'hDEBB20E3,
    parameter chk_mode_e   MODE    = CHK_COMPARE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sof,
    input  logic rx_bit_valid,
    input  logic rx_bit,
    input  logic rx_eof,
    output logic rx_crc_ok,
    output logic rx_crc_err,
    output logic rx_abort
);
    localparam int FILL_W = $clog2(CRC_W + 1);
    localparam int MOD_W  = $clog2(BYTE_W);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(CRC_W);

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [CRC_W-1:0]  win;
        logic [FILL_W-1:0] fill;
        logic [MOD_W-1:0]  bmod;
        logic              ok;
        logic              err;
        logic              abort;
    } rx_state_t;

    rx_state_t st_d, st_q;
    rx_state_t base, upd;
    logic      feed_bit, feed_en, match;
    logic [CRC_W-1:0] step_crc;

    always_comb begin
        base = st_q;
        if (rx_sof) begin
            base.crc  = PRESET[CRC_W-1:0];
            base.win  = '0;
            base.fill = '0;
            base.bmod = '0;
        end
    end

    generate
        if (MODE == CHK_RESIDUE) begin : g_residue
            assign feed_bit = rx_bit;
            assign feed_en  = 1'b1;
            assign match    = (upd.crc == RESIDUE[CRC_W-1:0]);
        end else begin : g_compare
            assign feed_bit = base.win[0];
            assign feed_en  = (base.fill == FULL);
            assign match    = (upd.win == ~upd.crc);
        end
    endgenerate

    irf_crc_step #(.CRC_W(CRC_W), .N(1), .POLY(POLY)) u_step (
        .crc_in  (base.crc),
        .din     (feed_bit),
        .crc_out (step_crc)
    );

    always_comb begin
        upd = base;
        if (rx_bit_valid) begin
            upd.win  = {rx_bit, base.win[CRC_W-1:1]};
            upd.bmod = base.bmod + 1'b1;
            if (base.fill != FULL) upd.fill = base.fill + 1'b1;
            if (feed_en) upd.crc = step_crc;
        end
    end

    always_comb begin
        st_d       = upd;
        st_d.ok    = 1'b0;
        st_d.err   = 1'b0;
        st_d.abort = 1'b0;
        if (rx_eof) begin
            if (upd.bmod != '0)      st_d.abort = 1'b1;
            else if (upd.fill != FULL) st_d.err = 1'b1;
            else if (match)          st_d.ok    = 1'b1;
            else                     st_d.err   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: PRESET[CRC_W-1:0], win: '0, fill: '0, bmod: '0,
                             ok: 1'b0, err: 1'b0, abort: 1'b0};
        else        st_q <= st_d;
    end

    assign rx_crc_ok  = st_q.ok;
    assign rx_crc_err = st_q.err;
    assign rx_abort   = st_q.abort;

    assert_single_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_crc_ok, rx_crc_err, rx_abort}));
    assert_result_follows_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_crc_ok || rx_crc_err || rx_abort) |-> $past(rx_eof));
    assert_ok_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_crc_ok && !$past(rx_eof, 1) == 1'b0) |=> (!rx_crc_ok || $past(rx_eof)));
    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FULL);
endmodule

// File: rtl/irf_fcs_unit.sv
module irf_fcs_unit
    import irf_fcs_pkg::*;
#(
    parameter int        CRC_W  = 32,
    parameter int        BYTE_W = 8,
    parameter int        NIB_W  = 4,
    parameter chk_mode_e RX_MODE = CHK_COMPARE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sof,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_eod,
    output logic              tx_busy,
    output logic              tx_nib_valid,
    output logic [NIB_W-1:0]  tx_nib,
    output logic              tx_nib_last,
    input  logic              rx_sof,
    input  logic              rx_bit_valid,
    input  logic              rx_bit,
    input  logic              rx_eof,
    output logic              rx_crc_ok,
    output logic              rx_crc_err,
    output logic              rx_abort
);
    irf_fcs_tx #(
        .CRC_W(CRC_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W),
        .POLY(FCS_POLY_REFL), .PRESET(FCS_PRESET)
    ) u_tx (
        .clk, .rst_n, .tx_sof, .tx_valid, .tx_byte, .tx_eod,
        .tx_busy, .tx_nib_valid, .tx_nib, .tx_nib_last
    );

    irf_fcs_rx #(
        .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(FCS_POLY_REFL),
        .PRESET(FCS_PRESET), .RESIDUE(FCS_RESIDUE), .MODE(RX_MODE)
    ) u_rx (
        .clk, .rst_n, .rx_sof, .rx_bit_valid, .rx_bit, .rx_eof,
        .rx_crc_ok, .rx_crc_err, .rx_abort
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_busy && !rx_crc_ok && !rx_crc_err && !rx_abort) || !rst_n);
endmodule

// File: tb/tb_irf_fcs_unit.sv
module tb_irf_fcs_unit;
    import irf_fcs_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       tx_sof = 0, tx_valid = 0, tx_eod = 0;
    logic [7:0] tx_byte = 0;
    logic       rx_sof = 0, rx_bit_valid = 0, rx_bit = 0, rx_eof = 0;
    logic       tx_busy, tx_nib_valid, tx_nib_last;
    logic [3:0] tx_nib;
    logic       rx_crc_ok, rx_crc_err, rx_abort;
    logic       r_busy, r_nv, r_nl, r_ok, r_err, r_ab;
    logic [3:0] r_nib;

    irf_fcs_unit dut (
        .clk, .rst_n, .tx_sof, .tx_valid, .tx_byte, .tx_eod,
        .tx_busy, .tx_nib_valid, .tx_nib, .tx_nib_last,
        .rx_sof, .rx_bit_valid, .rx_bit, .rx_eof,
        .rx_crc_ok, .rx_crc_err, .rx_abort
    );

    irf_fcs_unit #(.RX_MODE(CHK_RESIDUE)) dut_res (
        .clk, .rst_n, .tx_sof, .tx_valid, .tx_byte, .tx_eod,
        .tx_busy(r_busy), .tx_nib_valid(r_nv), .tx_nib(r_nib), .tx_nib_last(r_nl),
        .rx_sof, .rx_bit_valid, .rx_bit, .rx_eof,
        .rx_crc_ok(r_ok), .rx_crc_err(r_err), .rx_abort(r_ab)
    );

    int n_checks = 0, n_errs = 0;
    bit done = 0;
    logic [7:0] tbuf [0:31];
    logic       rbits [0:511];
    int         rlen;

    task automatic check(input bit cond, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!cond) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ tbuf[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        return ~c;
    endfunction

    task automatic load_check_string();
        for (int i = 0; i < 9; i++) tbuf[i] = 8'h31 + 8'(i);
    endtask

    // Transmit a frame of n bytes from tbuf and check the nibble trailer.
    task automatic tx_frame(input int n, input bit eod_sep, input bit junk, input string req);
        logic [31:0] exp = ref_fcs(n);
        for (int i = 0; i < n; i++) begin
            tx_sof = (i == 0); tx_valid = 1; tx_byte = tbuf[i];
            tx_eod = (!eod_sep && i == n - 1);
            @(negedge clk);
        end
        if (eod_sep || n == 0) begin
            tx_sof = (n == 0); tx_valid = 0; tx_eod = 1;
            @(negedge clk);
        end
        for (int k = 0; k < 8; k++) begin
            if (junk && k < 7) begin
                tx_sof = 1; tx_valid = 1; tx_byte = 8'hA5 ^ 8'(k); tx_eod = 1;
            end else begin
                tx_sof = 0; tx_valid = 0; tx_eod = 0;
            end
            check(tx_nib_valid && tx_busy, {req, " nib_valid"}, 32'(tx_nib_valid), 1);
            check(tx_nib == exp[k*4 +: 4], {req, " nibble"}, 32'(tx_nib), 32'(exp[k*4 +: 4]));
            check(tx_nib_last == (k == 7), {req, " nib_last"}, 32'(tx_nib_last), 32'(k == 7));
            @(negedge clk);
        end
        check(!tx_nib_valid && !tx_busy, {req, " trailer ends"}, 32'(tx_busy), 0);
    endtask

    // Build a bit stream: n bytes, optional trailer, bit flip, extra bits.
    task automatic build_rx(input int n, input bit trailer, input int flip, input int extra);
        logic [31:0] f = ref_fcs(n);
        rlen = 0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin rbits[rlen] = tbuf[i][b]; rlen++; end
        if (trailer)
            for (int b = 0; b < 32; b++) begin rbits[rlen] = f[b]; rlen++; end
        for (int e = 0; e < extra; e++) begin rbits[rlen] = e[0]; rlen++; end
        if (flip >= 0) rbits[flip] = ~rbits[flip];
    endtask

    // Send rbits; expected result: 0 ok, 1 err, 2 abort.
    task automatic rx_frame(input int expc, input string req);
        for (int k = 0; k < rlen; k++) begin
            rx_sof = (k == 0); rx_bit_valid = 1; rx_bit = rbits[k]; rx_eof = (k == rlen - 1);
            @(negedge clk);
        end
        rx_sof = 0; rx_bit_valid = 0; rx_eof = 0;
        check({rx_crc_ok, rx_crc_err, rx_abort} == {expc == 0, expc == 1, expc == 2}, req,
              32'({rx_crc_ok, rx_crc_err, rx_abort}), 32'({expc == 0, expc == 1, expc == 2}));
        check({r_ok, r_err, r_ab} == {expc == 0, expc == 1, expc == 2}, {req, " R10 residue"},
              32'({r_ok, r_err, r_ab}), 32'({expc == 0, expc == 1, expc == 2}));
        @(negedge clk);
        check({rx_crc_ok, rx_crc_err, rx_abort, r_ok, r_err, r_ab} == 6'b0, {req, " one-cycle"},
              32'({rx_crc_ok, rx_crc_err, rx_abort}), 0);
    endtask

    task automatic t_reset();
        check({tx_busy, tx_nib_valid, tx_nib_last, rx_crc_ok, rx_crc_err, rx_abort} == 6'b0,
              "R1 reset outputs", 32'({tx_busy, tx_nib_valid, rx_crc_ok, rx_crc_err, rx_abort}), 0);
    endtask

    task automatic t_tx_check_value();
        load_check_string();
        check(ref_fcs(9) == 32'hCBF43926, "R2 model check value", ref_fcs(9), 32'hCBF43926);
        tx_frame(9, 0, 0, "R2 R3 check string");
    endtask

    task automatic t_tx_patterns();
        for (int i = 0; i < 5; i++) tbuf[i] = 8'hC0 + 8'(i * 7);
        tx_frame(5, 1, 0, "R2 eod separate");
        tbuf[0] = 8'hFF;
        tx_frame(1, 0, 0, "R2 single byte");
        tx_frame(0, 1, 0, "R2 empty frame");
    endtask

    task automatic t_tx_ignore();
        for (int i = 0; i < 4; i++) tbuf[i] = 8'h10 * 8'(i + 1);
        tx_frame(4, 0, 1, "R4 inputs while busy");
        tx_frame(4, 0, 0, "R4 following frame");
    endtask

    task automatic t_rx_cases();
        load_check_string();
        build_rx(9, 1, -1, 0);  rx_frame(0, "R5 R6 good frame");
        for (int i = 0; i < 3; i++) tbuf[i] = 8'h5A ^ 8'(i);
        build_rx(3, 1, -1, 0);  rx_frame(0, "R6 short payload good");
        build_rx(0, 1, -1, 0);  rx_frame(0, "R6 trailer only");
        build_rx(3, 1, 5, 0);   rx_frame(1, "R7 data bit flipped");
        build_rx(3, 1, 40, 0);  rx_frame(1, "R7 trailer bit flipped");
        build_rx(2, 0, -1, 0);  rx_frame(1, "R7 under 32 bits");
        build_rx(3, 1, -1, 5);  rx_frame(2, "R8 partial byte");
        build_rx(0, 0, -1, 3);  rx_frame(2, "R8 three bits");
    endtask

    task automatic t_concurrent();
        load_check_string();
        build_rx(9, 1, -1, 0);
        fork
            tx_frame(9, 0, 0, "R9 tx alongside rx");
            rx_frame(0, "R9 rx alongside tx");
        join
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_check_value();
        t_tx_patterns();
        t_tx_ignore();
        t_rx_cases();
        t_concurrent();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule